// File: doc/BRIEF.md
# Dual-Channel Programmable Timer/Counter

This peripheral holds two identical timer/counter channels behind a small word-addressed register bus. Each channel has a control word, a reload value and a live count. Software stops a channel, places a value in its reload register, and uses the load bit to copy that value into the count. It then starts the channel counting up or down, in one-shot or auto-reload form. Each time the count passes its terminal value, the channel raises a sticky event flag. On the flag's rising edge it can also send a one-cycle interrupt pulse, if the channel's interrupt gate is open.

Writes take effect at the clock edge on which `wr_en` is sampled high. Reads are combinational from `addr`. A single control bit, written through either channel's control word, starts both channels in the same clock. Several control bits are kept only as storage and have no effect on counting: capture mode, the external strobe enables and the pulse-width option.

Top module: `twin_timer`

## Requirements
- R1: Byte addresses (the two low bits ignored) map as: channel 0 control 0x00, reload 0x04, count 0x08; channel 1 control 0x10, reload 0x14, count 0x18. Offsets 0x0C and 0x1C read 0, and writes to them are ignored. Writes to a count register are ignored. The reload registers read back what was written.
- R2: While `rst_n` is low at a clock edge, every register clears to 0 and `irq` clears to 0.
- R3: Control word bits are: 0 capture-mode storage, 1 direction (1 = down, 0 = up), 2 and 3 external-strobe storage, 4 auto-reload, 5 load, 6 interrupt gate, 7 run, 8 event flag, 9 pulse-width storage, 10 start-all. Bits 0-7 and 9 read back as written (subject to R8 and R11). Bit 10 and bits 11 and up always read 0.
- R4: While bit 5 is 1, the count takes the reload register's value at every edge and does not step.
- R5: While bit 7 is 0 and bit 5 is 0, the count holds its value.
- R6: While bit 7 is 1 and bit 5 is 0, the count steps by one at every edge: down when bit 1 is 1, up when bit 1 is 0.
- R7: A terminal event is a running step taken from 0 when counting down, or from all ones when counting up. With bit 4 set, that edge loads the count from the reload register and sets the flag, so the period is reload+1 cycles.
- R8: With bit 4 clear, a terminal event sets the count to 0, sets the flag and clears bit 7.
- R9: Writing a control word with bit 8 = 1 clears that channel's flag. Writing bit 8 = 0 leaves the flag unchanged.
- R10: `irq[k]` is high for exactly the one cycle after the edge on which channel k's flag goes from 0 to 1, and only if bit 6 was set. Bit 6 never changes the flag.
- R11: Writing any control word with bit 10 = 1 sets bit 7 of every channel at that edge.
- R12: Each channel's registers, flag and interrupt are independent of the other channel's, except through bit 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| addr | input | 5 | Byte address of the register to read or write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq | output | 2 | Per-channel one-cycle interrupt pulse |

## Verification
A write is due at edge e. It changes the control and reload registers right after e. Its effect on the count (load, first step, start-all) appears one edge later, at e+1. A terminal event shows its flag, its reloaded or zeroed count and its interrupt pulse together right after the edge that takes the terminal step. The pulse falls after the next edge. The bench drives each write so that it is sampled at one known edge. It then samples `rdata` and `irq` at the falling edge after each counted edge, so the expected count for every step is written down as an offset from that write edge. Long-lived results are checked with the counters stopped, so the time taken by the reads cannot shift them.

// File: rtl/twin_timer_pkg.sv
`timescale 1ns/1ps
// Package: shared control-word bit positions and register selector type for
// the dual timer. Assumes every channel uses the same 11-bit control layout.
package twin_timer_pkg;

    // Control word bit positions; software depends on these.
    localparam int BIT_CAPMODE = 0;
    localparam int BIT_DOWN    = 1;
    localparam int BIT_XGEN    = 2;
    localparam int BIT_XCAP    = 3;
    localparam int BIT_AUTO    = 4;
    localparam int BIT_LOAD    = 5;
    localparam int BIT_IEN     = 6;
    localparam int BIT_RUN     = 7;
    localparam int BIT_FLAG    = 8;
    localparam int BIT_PWM     = 9;
    localparam int BIT_ALL     = 10;

    // Stored control bits (0..9); bit 8 slot is kept zero, flag lives apart.
    localparam int CTL_W       = 10;

    // Word index inside one channel's 16-byte window.
    typedef enum logic [1:0] {
        SEL_CTL  = 2'd0,
        SEL_LOAD = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/twin_timer_decode.sv
`timescale 1ns/1ps
// Module: address decoder. Splits a word address into channel index and
// register selector, and produces per-channel write strobes plus the
// start-all pulse. Assumes NUM_CH is a power of two and at least 2.
module twin_timer_decode
    import twin_timer_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 32,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int WA_W  = CH_W + 2
) (
    input  logic              wr_en,
    input  logic [WA_W-1:0]   waddr,
    input  logic              wbit_all,
    output logic [CH_W-1:0]   ch_idx,
    output reg_sel_e          sel,
    output logic [NUM_CH-1:0] wr_ctl,
    output logic [NUM_CH-1:0] wr_load,
    output logic              start_all
);

    // Purpose: split the word address into channel and register fields.
    always_comb begin
        ch_idx = waddr[WA_W-1:2];
        sel    = reg_sel_e'(waddr[1:0]);
    end

    // Purpose: one write strobe per channel and register that accepts writes.
    for (genvar k = 0; k < NUM_CH; k++) begin : g_strobe
        always_comb begin
            wr_ctl[k]  = wr_en && (ch_idx == CH_W'(k)) && (sel == SEL_CTL);
            wr_load[k] = wr_en && (ch_idx == CH_W'(k)) && (sel == SEL_LOAD);
        end
    end

    // Purpose: start-all fires on any control write carrying bit 10.
    always_comb start_all = wr_en && (sel == SEL_CTL) && wbit_all;

endmodule

// File: rtl/twin_timer_chan.sv
`timescale 1ns/1ps
// Module: one timer/counter channel. Holds the control bits, the event flag,
// the reload value and the live count; produces a one-cycle interrupt on
// the flag's rising edge when the gate is open. Assumes DATA_W >= 11 and
// that write strobes are single-cycle and sampled at the rising edge.
module twin_timer_chan
    import twin_timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic              wr_load,
    input  logic              start_all,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctl_word,
    output logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] cnt_val,
    output logic              irq
);

    logic [CTL_W-1:0]  ctl_q;
    logic              flag_q;
    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] cnt_d;
    logic [CTL_W-1:0]  ctl_d;
    logic              at_end;
    logic              term;
    logic              stepping;

    // Purpose: detect the terminal step for the selected direction.
    always_comb begin
        stepping = ctl_q[BIT_RUN] && !ctl_q[BIT_LOAD];
        at_end   = ctl_q[BIT_DOWN] ? (cnt_q == '0) : (cnt_q == '1);
        term     = stepping && at_end;
    end

    // Purpose: next count from load, step, reload or one-shot stop.
    always_comb begin
        if (ctl_q[BIT_LOAD])
            cnt_d = load_q;
        else if (!ctl_q[BIT_RUN])
            cnt_d = cnt_q;
        else if (term)
            cnt_d = ctl_q[BIT_AUTO] ? load_q : '0;
        else if (ctl_q[BIT_DOWN])
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q + 1'b1;
    end

    // Purpose: next control bits; a bus write wins over the one-shot stop.
    always_comb begin
        if (wr_ctl) begin
            ctl_d           = wdata[CTL_W-1:0];
            ctl_d[BIT_FLAG] = 1'b0;
        end else begin
            ctl_d = ctl_q;
            if (term && !ctl_q[BIT_AUTO])
                ctl_d[BIT_RUN] = 1'b0;
        end
        if (start_all)
            ctl_d[BIT_RUN] = 1'b1;
    end

    // Purpose: control, reload and count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            load_q <= '0;
            cnt_q  <= '0;
        end else begin
            ctl_q <= ctl_d;
            cnt_q <= cnt_d;
            if (wr_load)
                load_q <= wdata;
        end
    end

    // Purpose: sticky event flag; a terminal event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (term)
            flag_q <= 1'b1;
        else if (wr_ctl && wdata[BIT_FLAG])
            flag_q <= 1'b0;
    end

    // Purpose: one-cycle interrupt on the flag's 0-to-1 edge, gated.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= term && !flag_q && ctl_q[BIT_IEN];
    end

    // Purpose: assemble the readable control word.
    always_comb begin
        ctl_word                = '0;
        ctl_word[CTL_W-1:0]     = ctl_q;
        ctl_word[BIT_FLAG]      = flag_q;
    end

    assign load_val = load_q;
    assign cnt_val  = cnt_q;

    // R4: a loading channel copies the reload value at the next edge.
    a_r4_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[BIT_LOAD] |=> (cnt_q == $past(load_q)));

    // R5: a stopped channel keeps its count.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q[BIT_LOAD] && !ctl_q[BIT_RUN]) |=> $stable(cnt_q));

    // R6: a running down counter away from zero decrements by one.
    a_r6_down_step: assert property (@(posedge clk) disable iff (!rst_n)
        (stepping && ctl_q[BIT_DOWN] && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R6: a running up counter below all ones increments by one.
    a_r6_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (stepping && !ctl_q[BIT_DOWN] && cnt_q != '1) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R7: an auto-reload terminal step reloads and raises the flag.
    a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (term && ctl_q[BIT_AUTO]) |=> (cnt_q == $past(load_q) && flag_q));

    // R8: a one-shot terminal step zeroes the count and stops the channel.
    a_r8_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (term && !ctl_q[BIT_AUTO] && !wr_ctl && !start_all) |=> (cnt_q == '0 && !ctl_q[BIT_RUN] && flag_q));

    // R9: the flag stays set unless a write-one clears it.
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_ctl && wdata[BIT_FLAG])) |=> flag_q);

    // R10: the interrupt lasts one cycle and only accompanies a set flag.
    a_r10_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    a_r10_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_q && !$past(flag_q) && $past(ctl_q[BIT_IEN])));

    // R11: start-all leaves the channel running after the edge.
    a_r11_start_all: assert property (@(posedge clk) disable iff (!rst_n)
        start_all |=> ctl_q[BIT_RUN]);

endmodule

// File: rtl/twin_timer_rdmux.sv
`timescale 1ns/1ps
// Module: read-data multiplexer. Picks the addressed channel's control,
// reload or count word; the spare word slot reads zero. Assumes the
// channel index is always below NUM_CH (true for a power-of-two count).
module twin_timer_rdmux
    import twin_timer_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 32,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [CH_W-1:0]   ch_idx,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] ctl_words [NUM_CH],
    input  logic [DATA_W-1:0] load_vals [NUM_CH],
    input  logic [DATA_W-1:0] cnt_vals  [NUM_CH],
    output logic [DATA_W-1:0] rdata
);

    // Purpose: select the addressed word.
    always_comb begin
        unique case (sel)
            SEL_CTL:  rdata = ctl_words[ch_idx];
            SEL_LOAD: rdata = load_vals[ch_idx];
            SEL_CNT:  rdata = cnt_vals[ch_idx];
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/twin_timer.sv
`timescale 1ns/1ps
// Module: top of the dual timer/counter. Decodes the register bus, holds
// NUM_CH channels and returns combinational read data. Assumes a 16-byte
// window per channel and byte addresses whose two low bits are ignored.
module twin_timer
    import twin_timer_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 32,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int ADDR_W = CH_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] irq
);

    logic [CH_W-1:0]   ch_idx;
    reg_sel_e          sel;
    logic [NUM_CH-1:0] wr_ctl;
    logic [NUM_CH-1:0] wr_load;
    logic              start_all;
    logic [DATA_W-1:0] ctl_words [NUM_CH];
    logic [DATA_W-1:0] load_vals [NUM_CH];
    logic [DATA_W-1:0] cnt_vals  [NUM_CH];
    logic [1:0]        unused_byte_lane;

    assign unused_byte_lane = addr[1:0];

    twin_timer_decode #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) decode_i (
        .wr_en     (wr_en),
        .waddr     (addr[ADDR_W-1:2]),
        .wbit_all  (wdata[BIT_ALL]),
        .ch_idx    (ch_idx),
        .sel       (sel),
        .wr_ctl    (wr_ctl),
        .wr_load   (wr_load),
        .start_all (start_all)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
        twin_timer_chan #(.DATA_W(DATA_W)) chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_ctl    (wr_ctl[k]),
            .wr_load   (wr_load[k]),
            .start_all (start_all),
            .wdata     (wdata),
            .ctl_word  (ctl_words[k]),
            .load_val  (load_vals[k]),
            .cnt_val   (cnt_vals[k]),
            .irq       (irq[k])
        );
    end

    twin_timer_rdmux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) rdmux_i (
        .ch_idx    (ch_idx),
        .sel       (sel),
        .ctl_words (ctl_words),
        .load_vals (load_vals),
        .cnt_vals  (cnt_vals),
        .rdata     (rdata)
    );

    // R1: the spare word slot of every channel reads zero.
    a_r1_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[3:2] == 2'b11) |-> (rdata == '0));

    // R3: the start-all bit never reads back as set.
    a_r3_all_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[3:2] == 2'b00) |-> (rdata[BIT_ALL] == 1'b0));

    // R2: irq is quiet in the cycle after a reset edge.
    a_r2_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (irq == '0));

endmodule

// File: tb/twin_timer_tb.sv
`timescale 1ns/1ps
// Bench for twin_timer: a vector table walked by one loop, then directed
// tests for reset, auto-reload, one-shot, interrupt gating and start-all.
module twin_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    twin_timer dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    typedef struct packed {
        logic [1:0]  op;    // 0 write, 1 read-compare, 2 idle cycles
        logic [4:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 5'h04, 32'h1234_5678, 32'h0,          4'd1 },  // R1
        '{2'd1, 5'h04, 32'h0,         32'h1234_5678, 4'd1 },  // R1
        '{2'd0, 5'h14, 32'hCAFE_0001, 32'h0,          4'd1 },  // R1
        '{2'd1, 5'h14, 32'h0,         32'hCAFE_0001, 4'd1 },  // R1
        '{2'd1, 5'h04, 32'h0,         32'h1234_5678, 4'd12},  // R12
        '{2'd0, 5'h00, 32'hFFFF_FA5F, 32'h0,          4'd3 },  // R3
        '{2'd1, 5'h00, 32'h0,         32'h0000_025F, 4'd3 },  // R3
        '{2'd1, 5'h10, 32'h0,         32'h0,          4'd12},  // R12
        '{2'd0, 5'h08, 32'h0000_DEAD, 32'h0,          4'd1 },  // R1
        '{2'd1, 5'h08, 32'h0,         32'h0,          4'd1 },  // R1
        '{2'd0, 5'h0C, 32'hFFFF_FFFF, 32'h0,          4'd1 },  // R1
        '{2'd1, 5'h0C, 32'h0,         32'h0,          4'd1 },  // R1
        '{2'd1, 5'h1C, 32'h0,         32'h0,          4'd1 },  // R1
        '{2'd0, 5'h00, 32'h0000_0020, 32'h0,          4'd4 },  // R4
        '{2'd2, 5'h00, 32'd1,         32'h0,          4'd4 },  // R4
        '{2'd1, 5'h08, 32'h0,         32'h1234_5678, 4'd4 },  // R4
        '{2'd0, 5'h00, 32'h0,         32'h0,          4'd5 },  // R5
        '{2'd2, 5'h00, 32'd3,         32'h0,          4'd5 },  // R5
        '{2'd1, 5'h08, 32'h0,         32'h1234_5678, 4'd5 }   // R5
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive a write sampled at the next rising edge; returns at the falling edge after it.
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        addr = a;
        #0.2;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements) actual expired expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] v1;
        logic [31:0] exp_dn [8] = '{32'd2, 32'd1, 32'd0, 32'd3, 32'd2, 32'd1, 32'd0, 32'd3};

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: every register reads zero after reset, no interrupt.
        for (int a = 0; a < 32; a += 4) begin
            rd(5'(a), v);
            chk(v, 32'h0, $sformatf("R2 reset read @%0h", a));
            if (a == 12) @(negedge clk);
        end
        chk({30'h0, irq}, 32'h0, "R2 irq after reset");

        // Table walk: storage, decode and hold behaviour with counters stopped.
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            case (TBL[i].op)
                2'd0: wr(TBL[i].addr, TBL[i].data);
                2'd1: begin
                    rd(TBL[i].addr, v);
                    chk(v, TBL[i].exp, $sformatf("R%0d table row %0d", TBL[i].req, i));
                end
                default: idle(int'(TBL[i].data));
            endcase
        end

        // R7: down auto-reload from 3, period 4, irq on first event only.
        wr(5'h04, 32'd3);
        wr(5'h00, 32'h20);
        idle(1);
        wr(5'h00, 32'hD2);
        addr = 5'h08;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk);
            @(negedge clk);
            #0.2;
            chk(rdata, exp_dn[i], $sformatf("R7 down reload count step %0d", i + 1));
            chk({31'h0, irq[0]}, (i == 3) ? 32'd1 : 32'd0, $sformatf("R10 irq0 step %0d", i + 1));
        end
        // R9: writing flag bit 0 keeps the flag; writing 1 clears it.
        wr(5'h00, 32'h12);
        rd(5'h00, v);
        chk(v, 32'h112, "R9 flag kept on write of 0");
        wr(5'h00, 32'h100);
        rd(5'h00, v);
        chk(v, 32'h0, "R9 flag cleared on write of 1");

        // R8: up one-shot on channel 1 wraps to 0 and stops.
        wr(5'h14, 32'hFFFF_FFFE);
        wr(5'h10, 32'h20);
        idle(1);
        wr(5'h10, 32'hC0);
        addr = 5'h18;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk);
            @(negedge clk);
            #0.2;
            chk(rdata, (i == 0) ? 32'hFFFF_FFFF : 32'h0, $sformatf("R8 one-shot count step %0d", i + 1));
            chk({30'h0, irq}, (i == 1) ? 32'd2 : 32'd0, $sformatf("R12 irq vector step %0d", i + 1));
        end
        rd(5'h10, v);
        chk(v, 32'h140, "R8 run bit cleared, flag set");

        // R10: gate closed, one-shot down from 1 sets the flag but no pulse.
        wr(5'h04, 32'd1);
        wr(5'h00, 32'h20);
        idle(1);
        wr(5'h00, 32'h82);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk({31'h0, irq[0]}, 32'd0, $sformatf("R10 gated irq0 step %0d", i + 1));
        end
        rd(5'h00, v);
        chk(v, 32'h102, "R10 flag set with gate closed");
        wr(5'h00, 32'h42);
        rd(5'h00, v);
        chk(v, 32'h142, "R10 opening gate keeps flag");
        chk({31'h0, irq[0]}, 32'd0, "R10 no pulse on gate open");

        // R11: start-all from channel 0's control word starts both channels.
        wr(5'h04, 32'd5);
        wr(5'h00, 32'h20);
        wr(5'h14, 32'd10);
        wr(5'h10, 32'h20);
        idle(1);
        wr(5'h10, 32'h100);
        wr(5'h00, 32'h100);
        wr(5'h00, 32'h412);
        rd(5'h00, v);
        rd(5'h10, v1);
        chk(v, 32'h092, "R11 channel 0 running, bit 10 reads 0");
        chk(v1, 32'h080, "R11 channel 1 running");
        idle(3);
        rd(5'h08, v);
        rd(5'h18, v1);
        chk(v, 32'd2, "R11 channel 0 counted down 3");
        chk(v1, 32'd13, "R11 channel 1 counted up 3");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule